// File: doc/BRIEF.md
# OFDM Frame Airtime Duration Calculator

This block works out how long an OFDM frame occupies the medium, in microseconds. A request carries a length in bytes, a bit rate in units of 100 kbit/s, a bandwidth mode and a short-preamble flag. The per-mode interframe gaps, the preamble times, the symbol time and the count of PLCP overhead bits come in on configuration inputs.

The block scales the timing figures for the narrow-band modes. It finds the number of symbols with a ceiling division, done by a sequential restoring divider. The result is returned through a valid/ready pair, and it saturates at the top of its 16-bit range.

The same datapath can also fill a 12-entry ACK-duration table, one entry for each transmit rate. Each entry holds the airtime of a 10-byte ACK sent at the ACK rate that goes with that transmit rate. The ACK rate is either the base rate (1 Mb/s for the four CCK rates, 6 Mb/s for the OFDM rates) or a faster rate tied to the transmit rate. When the ACK rate can use a short preamble, a second entry goes out at a fixed address offset. Every table entry uses the same OFDM airtime formula; the only CCK-specific rule kept is the short-preamble reduction.

Top module: `airtime_calc`

## Requirements
- R1: In mode 0 (default), with bits = plcp + 8·len, symbols = ceil(10·bits / (rate·sym)) and the result = SIFS_default + preamble + sym·symbols.
- R2: In mode 2 (half rate), the preamble and the symbol time are doubled, the rate is halved rounding up, and the half-rate SIFS is used.
- R3: In mode 3 (quarter rate), the preamble and the symbol time are multiplied by four, the rate is divided by four rounding up, and the quarter-rate SIFS is used.
- R4: In mode 1 (turbo), the turbo SIFS and the minimum preamble are used, and the symbol time and the rate are left unscaled.
- R5: In mode 0 a set short flag lowers the result by 96, with a floor of zero. In modes 1 to 3 the short flag has no effect on the result.
- R6: The result is 0xFFFF when the true duration exceeds 0xFFFF, and also when the scaled rate or the symbol time is zero.
- R7: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready stays low from that edge until the result has been consumed. res_valid and res_dur stay stable until res_ready is seen.
- R8: A fill writes the entries for transmit-rate indices 0..11 (1, 2, 5.5, 11, 6, 9, 12, 18, 24, 36, 48, 54 Mb/s) to address = index. Each entry is the 10-byte duration in the bandwidth mode sampled at fill start. With fill_ack_high low, indices 0..3 use 1 Mb/s and indices 4..11 use 6 Mb/s.
- R9: With fill_ack_high high, the ACK rate for each index is: index 0 → 1 Mb/s, 1..3 → 2 Mb/s, 4..5 → 6 Mb/s, 6..7 → 12 Mb/s, 8..11 → 24 Mb/s.
- R10: When the ACK rate is 2, 5.5 or 11 Mb/s, a second write with the short flag applied goes to address index + 16 straight after the long entry. Writes go in ascending index order, and fill_done is high together with the final write only.
- R11: In idle, fill_start wins over req_valid: req_ready is low while fill_start is high and for the whole fill. A request held pending during that time is accepted after the fill ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_len | input | 12 | Frame length in bytes |
| req_rate | input | 10 | Bit rate in 100 kbit/s units |
| req_mode | input | 2 | Bandwidth mode: 0 default, 1 turbo, 2 half, 3 quarter (also used by a fill) |
| req_short | input | 1 | Short-preamble request |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumed |
| res_dur | output | 16 | Duration in microseconds, saturated |
| fill_start | input | 1 | Start filling the ACK table |
| fill_ack_high | input | 1 | Use rate-tied ACK rates for the fill |
| fill_done | output | 1 | High with the final table write |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | 5 | Table write address |
| tbl_data | output | 16 | Table write data (duration) |
| cfg_plcp_bits | input | 6 | PLCP overhead bits |
| cfg_sym_us | input | 6 | Base OFDM symbol time |
| cfg_pre_us | input | 8 | Base preamble time |
| cfg_pre_min_us | input | 8 | Minimum preamble time (turbo) |
| cfg_sifs_def_us | input | 8 | SIFS for the default mode |
| cfg_sifs_turbo_us | input | 8 | SIFS for turbo |
| cfg_sifs_half_us | input | 8 | SIFS for half rate |
| cfg_sifs_quarter_us | input | 8 | SIFS for quarter rate |

## Verification
Some conditions are hard to reach with ordinary frame parameters: the saturation and zero-divisor outcomes, and the short-preamble floor at zero. To reach the floor, the stimulus sets SIFS, preamble and PLCP bits to zero. To reach saturation, it uses a quarter-rate maximum-length frame at the slowest rate. To reach the zero divisor, it uses a zero rate and a zero symbol time.

A request that arrives in the same cycle as a fill start is also hard to bring about. The bench raises both strobes on one edge and keeps the request pending through the whole fill. It then checks that the table writes came first and that the request is still answered correctly afterwards. Randomised configurations and frames, with random result back-pressure, cover the arithmetic and the handshake hold.

// File: rtl/airtime_pkg.sv
package airtime_pkg;

  typedef enum logic [1:0] {
    BW_DEFAULT = 2'd0,
    BW_TURBO   = 2'd1,
    BW_HALF    = 2'd2,
    BW_QUARTER = 2'd3
  } bw_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DIV  = 2'd2,
    ST_RESP = 2'd3
  } calc_state_e;

  localparam int unsigned SHORT_CUT_US = 96;

  // transmit-rate table in 100 kbit/s units, index order as in R8
  function automatic int unsigned rate_of(input int unsigned idx);
    case (idx)
      0: rate_of = 10;
      1: rate_of = 20;
      2: rate_of = 55;
      3: rate_of = 110;
      4: rate_of = 60;
      5: rate_of = 90;
      6: rate_of = 120;
      7: rate_of = 180;
      8: rate_of = 240;
      9: rate_of = 360;
      10: rate_of = 480;
      11: rate_of = 540;
      default: rate_of = 0;
    endcase
  endfunction

  // which table index supplies the ACK rate for a given transmit index
  function automatic int unsigned ack_index(input int unsigned idx, input logic high);
    if (!high) ack_index = (idx < 4) ? 0 : 4;
    else if (idx == 0) ack_index = 0;
    else if (idx < 4) ack_index = 1;
    else if (idx < 6) ack_index = 4;
    else if (idx < 8) ack_index = 6;
    else ack_index = 8;
  endfunction

  function automatic logic short_capable(input int unsigned idx);
    short_capable = (idx >= 1) && (idx <= 3);
  endfunction

  // gap + preamble + symbols, with optional short-preamble reduction
  function automatic logic [31:0] airtime_sum(input logic [31:0] gap, input logic [31:0] pre,
                                              input logic [31:0] sym, input logic [31:0] nsym,
                                              input logic cut);
    logic [31:0] s;
    s = gap + pre + sym * nsym;
    if (cut) s = (s > SHORT_CUT_US) ? (s - SHORT_CUT_US) : 32'd0;
    airtime_sum = s;
  endfunction

endpackage

// File: rtl/airtime_scaler.sv
module airtime_scaler
  import airtime_pkg::*;
#(
  parameter int RATE_W = 10,
  parameter int SYM_W  = 6,
  parameter int PRE_W  = 8,
  parameter int SIFS_W = 8
) (
  input  bw_mode_e              mode,
  input  logic [RATE_W-1:0]     rate,
  input  logic [SYM_W-1:0]      sym,
  input  logic [PRE_W-1:0]      pre,
  input  logic [PRE_W-1:0]      pre_min,
  input  logic [SIFS_W-1:0]     sifs_def,
  input  logic [SIFS_W-1:0]     sifs_turbo,
  input  logic [SIFS_W-1:0]     sifs_half,
  input  logic [SIFS_W-1:0]     sifs_quarter,
  output logic [SIFS_W-1:0]     gap_s,
  output logic [PRE_W+1:0]      pre_s,
  output logic [SYM_W+1:0]      sym_s,
  output logic [RATE_W-1:0]     rate_s
);
  logic [RATE_W:0]   rate_p1;
  logic [RATE_W+1:0] rate_p3;

  assign rate_p1 = {1'b0, rate} + (RATE_W+1)'(1);
  assign rate_p3 = {2'b00, rate} + (RATE_W+2)'(3);

  always_comb begin
    case (mode)
      BW_TURBO: begin
        gap_s  = sifs_turbo;
        pre_s  = {2'b00, pre_min};
        sym_s  = {2'b00, sym};
        rate_s = rate;
      end
      BW_HALF: begin
        gap_s  = sifs_half;
        pre_s  = {1'b0, pre, 1'b0};
        sym_s  = {1'b0, sym, 1'b0};
        rate_s = rate_p1[RATE_W:1];
      end
      BW_QUARTER: begin
        gap_s  = sifs_quarter;
        pre_s  = {pre, 2'b00};
        sym_s  = {sym, 2'b00};
        rate_s = rate_p3[RATE_W+1:2];
      end
      default: begin
        gap_s  = sifs_def;
        pre_s  = {2'b00, pre};
        sym_s  = {2'b00, sym};
        rate_s = rate;
      end
    endcase
  end
endmodule

// File: rtl/airtime_div.sv
module airtime_div #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic             den_zero,
  output logic [NUM_W:0]   quot_ceil
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem;
  logic [NUM_W-1:0] q;
  logic [DEN_W-1:0] d;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W+1:0] trial;
  logic             ge;

  assign rem_sh = {rem[DEN_W-1:0], q[NUM_W-1]};
  assign trial  = {1'b0, rem_sh} - {2'b00, d};
  assign ge     = ~trial[DEN_W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      q    <= '0;
      d    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        q    <= num;
        d    <= den;
        cnt  <= CNT_W'(NUM_W);
        busy <= 1'b1;
      end else if (busy) begin
        rem <= ge ? trial[DEN_W:0] : rem_sh;
        q   <= {q[NUM_W-2:0], ge};
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign den_zero  = (d == '0);
  assign quot_ceil = {1'b0, q} + (NUM_W+1)'(rem != '0);
endmodule

// File: rtl/airtime_ack_seq.sv
module airtime_ack_seq
  import airtime_pkg::*;
#(
  parameter int N_RATES   = 12,
  parameter int ADDR_W    = 5,
  parameter int SHORT_OFS = 16,
  parameter int RATE_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  logic              high_in,
  output logic [RATE_W-1:0] rate,
  output logic              short_sel,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam int IDX_W = $clog2(N_RATES);

  logic [IDX_W-1:0] idx;
  logic             phase;
  logic             high;
  int unsigned      ai;
  logic             cap;

  always_comb begin
    ai   = ack_index(32'(idx), high);
    rate = RATE_W'(rate_of(ai));
    cap  = short_capable(ai);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= 1'b0;
      high  <= 1'b0;
    end else if (start) begin
      idx   <= '0;
      phase <= 1'b0;
      high  <= high_in;
    end else if (adv) begin
      if (!phase && cap) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        idx   <= idx + IDX_W'(1);
      end
    end
  end

  assign short_sel = phase;
  assign addr      = phase ? (ADDR_W'(idx) + ADDR_W'(SHORT_OFS)) : ADDR_W'(idx);
  assign last      = (32'(idx) == 32'(N_RATES - 1)) && (phase || !cap);
endmodule

// File: rtl/airtime_calc.sv
module airtime_calc
  import airtime_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int RATE_W    = 10,
  parameter int PLCP_W    = 6,
  parameter int SYM_W     = 6,
  parameter int PRE_W     = 8,
  parameter int SIFS_W    = 8,
  parameter int DUR_W     = 16,
  parameter int N_RATES   = 12,
  parameter int ADDR_W    = 5,
  parameter int SHORT_OFS = 16,
  parameter int ACK_LEN   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [RATE_W-1:0] req_rate,
  input  logic [1:0]        req_mode,
  input  logic              req_short,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DUR_W-1:0]  res_dur,
  input  logic              fill_start,
  input  logic              fill_ack_high,
  output logic              fill_done,
  output logic              tbl_we,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic [DUR_W-1:0]  tbl_data,
  input  logic [PLCP_W-1:0] cfg_plcp_bits,
  input  logic [SYM_W-1:0]  cfg_sym_us,
  input  logic [PRE_W-1:0]  cfg_pre_us,
  input  logic [PRE_W-1:0]  cfg_pre_min_us,
  input  logic [SIFS_W-1:0] cfg_sifs_def_us,
  input  logic [SIFS_W-1:0] cfg_sifs_turbo_us,
  input  logic [SIFS_W-1:0] cfg_sifs_half_us,
  input  logic [SIFS_W-1:0] cfg_sifs_quarter_us
);
  localparam int BITS_W  = LEN_W + 4;
  localparam int NUM_W   = BITS_W + 4;
  localparam int DEN_W   = RATE_W + SYM_W + 2;
  localparam logic [31:0] DUR_MAX = (32'd1 << DUR_W) - 32'd1;

  calc_state_e       state;
  bw_mode_e          op_mode;
  logic              op_fill;
  logic [LEN_W-1:0]  op_len;
  logic [RATE_W-1:0] op_rate;
  logic              op_short;
  logic [PLCP_W-1:0] op_plcp;
  logic [SYM_W-1:0]  op_sym;
  logic [PRE_W-1:0]  op_pre, op_pre_min;
  logic [SIFS_W-1:0] op_sifs_def, op_sifs_turbo, op_sifs_half, op_sifs_quarter;

  // named events for the checker
  logic evt_accept, evt_consume, fill_busy, seq_start, seq_adv;
  logic div_start, div_busy, div_done, den_zero;

  logic [RATE_W-1:0] seq_rate;
  logic              seq_short, seq_last;
  logic [ADDR_W-1:0] seq_addr;

  logic [LEN_W-1:0]  eff_len;
  logic [RATE_W-1:0] eff_rate;
  logic              eff_short;
  logic [SIFS_W-1:0] gap_s;
  logic [PRE_W+1:0]  pre_s;
  logic [SYM_W+1:0]  sym_s;
  logic [RATE_W-1:0] rate_s;
  logic [BITS_W-1:0] bits;
  logic [NUM_W-1:0]  num;
  logic [DEN_W-1:0]  den;
  logic [NUM_W:0]    nsym;
  logic [31:0]       sum32;
  logic [DUR_W-1:0]  dur_now;

  assign req_ready   = (state == ST_IDLE) && !fill_start;
  assign evt_accept  = req_valid && req_ready;
  assign evt_consume = res_valid && res_ready;
  assign seq_start   = (state == ST_IDLE) && fill_start;
  assign fill_busy   = op_fill && (state != ST_IDLE);
  assign div_start   = (state == ST_LOAD);
  assign seq_adv     = (state == ST_DIV) && div_done && op_fill && !seq_last;

  assign eff_len   = op_fill ? LEN_W'(ACK_LEN) : op_len;
  assign eff_rate  = op_fill ? seq_rate : op_rate;
  assign eff_short = op_fill ? seq_short : op_short;

  airtime_scaler #(.RATE_W(RATE_W), .SYM_W(SYM_W), .PRE_W(PRE_W), .SIFS_W(SIFS_W)) u_scale (
    .mode(op_mode), .rate(eff_rate), .sym(op_sym), .pre(op_pre), .pre_min(op_pre_min),
    .sifs_def(op_sifs_def), .sifs_turbo(op_sifs_turbo), .sifs_half(op_sifs_half),
    .sifs_quarter(op_sifs_quarter), .gap_s(gap_s), .pre_s(pre_s), .sym_s(sym_s), .rate_s(rate_s)
  );

  assign bits = BITS_W'(op_plcp) + (BITS_W'(eff_len) << 3);
  assign num  = NUM_W'(bits) * NUM_W'(10);
  assign den  = DEN_W'(rate_s) * DEN_W'(sym_s);

  airtime_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(num), .den(den),
    .busy(div_busy), .done(div_done), .den_zero(den_zero), .quot_ceil(nsym)
  );

  airtime_ack_seq #(.N_RATES(N_RATES), .ADDR_W(ADDR_W), .SHORT_OFS(SHORT_OFS), .RATE_W(RATE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .adv(seq_adv), .high_in(fill_ack_high),
    .rate(seq_rate), .short_sel(seq_short), .addr(seq_addr), .last(seq_last)
  );

  assign sum32   = airtime_sum(32'(gap_s), 32'(pre_s), 32'(sym_s), 32'(nsym),
                               eff_short && (op_mode == BW_DEFAULT));
  assign dur_now = (den_zero || (sum32 > DUR_MAX)) ? DUR_MAX[DUR_W-1:0] : sum32[DUR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      op_mode         <= BW_DEFAULT;
      op_fill         <= 1'b0;
      op_len          <= '0;
      op_rate         <= '0;
      op_short        <= 1'b0;
      op_plcp         <= '0;
      op_sym          <= '0;
      op_pre          <= '0;
      op_pre_min      <= '0;
      op_sifs_def     <= '0;
      op_sifs_turbo   <= '0;
      op_sifs_half    <= '0;
      op_sifs_quarter <= '0;
      res_valid       <= 1'b0;
      res_dur         <= '0;
      tbl_we          <= 1'b0;
      tbl_addr        <= '0;
      tbl_data        <= '0;
      fill_done       <= 1'b0;
    end else begin
      tbl_we    <= 1'b0;
      fill_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (seq_start || evt_accept) begin
            op_fill         <= seq_start;
            op_mode         <= bw_mode_e'(req_mode);
            op_len          <= req_len;
            op_rate         <= req_rate;
            op_short        <= req_short;
            op_plcp         <= cfg_plcp_bits;
            op_sym          <= cfg_sym_us;
            op_pre          <= cfg_pre_us;
            op_pre_min      <= cfg_pre_min_us;
            op_sifs_def     <= cfg_sifs_def_us;
            op_sifs_turbo   <= cfg_sifs_turbo_us;
            op_sifs_half    <= cfg_sifs_half_us;
            op_sifs_quarter <= cfg_sifs_quarter_us;
            state           <= ST_LOAD;
          end
        end
        ST_LOAD: state <= ST_DIV;
        ST_DIV: begin
          if (div_done) begin
            if (op_fill) begin
              tbl_we   <= 1'b1;
              tbl_addr <= seq_addr;
              tbl_data <= dur_now;
              if (seq_last) begin
                fill_done <= 1'b1;
                state     <= ST_IDLE;
              end else begin
                state <= ST_LOAD;
              end
            end else begin
              res_dur   <= dur_now;
              res_valid <= 1'b1;
              state     <= ST_RESP;
            end
          end
        end
        default: begin
          if (evt_consume) begin
            res_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/airtime_calc_chk.sv
module airtime_calc_chk #(
  parameter int N_RATES   = 12,
  parameter int ADDR_W    = 5,
  parameter int SHORT_OFS = 16,
  parameter int DUR_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DUR_W-1:0]  res_dur,
  input logic              tbl_we,
  input logic [ADDR_W-1:0] tbl_addr,
  input logic              fill_done,
  input logic              evt_accept,
  input logic              fill_busy,
  input logic              div_busy,
  input logic              div_done
);
  // R7: result held stable under back-pressure
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_dur));

  // R7: no new request while a result is pending
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R7: an accepted request closes the door on the next cycle
  a_r7_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> !req_ready);

  // R11: fill blocks requests
  a_r11_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !req_ready);

  // R10: writes land only in the long or short address range
  a_r10_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> ((32'(tbl_addr) < N_RATES) ||
                ((32'(tbl_addr) >= SHORT_OFS) && (32'(tbl_addr) < SHORT_OFS + N_RATES))));

  // R10: completion flagged only together with a write
  a_r10_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> tbl_we);

  // R1: divider finishes before its result is used
  a_r1_div_settled: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> !div_busy);

  // R8: table writes and request results never coincide
  a_r8_write_excl: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> !res_valid);
endmodule

bind airtime_calc airtime_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_dur(res_dur), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
  .fill_done(fill_done), .evt_accept(evt_accept), .fill_busy(fill_busy),
  .div_busy(div_busy), .div_done(div_done)
);

// File: tb/tb_airtime_calc.sv
module tb_airtime_calc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 0, req_ready, req_short = 0, res_valid, res_ready = 0;
  logic [11:0] req_len = 0;
  logic [9:0]  req_rate = 0;
  logic [1:0]  req_mode = 0;
  logic [15:0] res_dur, tbl_data;
  logic fill_start = 0, fill_ack_high = 0, fill_done, tbl_we;
  logic [4:0] tbl_addr;
  logic [5:0] cfg_plcp_bits, cfg_sym_us;
  logic [7:0] cfg_pre_us, cfg_pre_min_us, cfg_sifs_def_us, cfg_sifs_turbo_us;
  logic [7:0] cfg_sifs_half_us, cfg_sifs_quarter_us;

  airtime_calc dut (.*);

  int total = 0, bad = 0;
  int wr_addr[64], wr_data[64], wr_last[64];
  int wr_n = 0;
  int rates[12] = '{10, 20, 55, 110, 60, 90, 120, 180, 240, 360, 480, 540};

  always @(negedge clk) if (tbl_we && wr_n < 64) begin
    wr_addr[wr_n] = int'(tbl_addr);
    wr_data[wr_n] = int'(tbl_data);
    wr_last[wr_n] = int'(fill_done);
    wr_n++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model(input int len, input int rate, input int mode, input bit sh);
    longint k, gap, p, st, r, nb, d, syms;
    case (mode)
      0: begin gap = cfg_sifs_def_us;     p = cfg_pre_us;     k = 1; end
      1: begin gap = cfg_sifs_turbo_us;   p = cfg_pre_min_us; k = 1; end
      2: begin gap = cfg_sifs_half_us;    p = 2 * cfg_pre_us; k = 2; end
      default: begin gap = cfg_sifs_quarter_us; p = 4 * cfg_pre_us; k = 4; end
    endcase
    st = k * cfg_sym_us;
    r  = (rate + k - 1) / k;
    if (r * st == 0) return 65535;
    nb = 10 * (cfg_plcp_bits + 8 * len);
    syms = nb / (r * st);
    if (syms * r * st < nb) syms++;
    d = gap + p + st * syms;
    if (mode == 0 && sh) d = (d > 96) ? d - 96 : 0;
    if (d > 65535) d = 65535;
    return d;
  endfunction

  function automatic int ack_of(input int i, input bit hi);
    int tgt[12] = '{0, 1, 1, 1, 4, 4, 6, 6, 8, 8, 8, 8};
    if (hi) return tgt[i];
    return (i < 4) ? 0 : 4;
  endfunction

  function automatic string mtag(input int mode);
    case (mode) 0: return "R1"; 1: return "R4"; 2: return "R2"; default: return "R3"; endcase
  endfunction

  task automatic set_cfg(input int plcp, sym, pre, pmin, s0, s1, s2, s3);
    cfg_plcp_bits = 6'(plcp); cfg_sym_us = 6'(sym); cfg_pre_us = 8'(pre); cfg_pre_min_us = 8'(pmin);
    cfg_sifs_def_us = 8'(s0); cfg_sifs_turbo_us = 8'(s1);
    cfg_sifs_half_us = 8'(s2); cfg_sifs_quarter_us = 8'(s3);
  endtask

  task automatic do_req(input string tag, input int len, rate, mode, input bit sh, input int hold);
    int cnt;
    bit hold_ok;
    logic [15:0] first;
    longint exp;
    exp = model(len, rate, mode, sh);
    @(negedge clk);
    req_len = 12'(len); req_rate = 10'(rate); req_mode = 2'(mode); req_short = sh; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!res_valid) chk({tag, " R7 closed after accept"}, req_ready, 0);
    cnt = 0;
    while (!res_valid && cnt < 2000) begin @(negedge clk); cnt++; end
    first = res_dur;
    hold_ok = 1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!res_valid || res_dur != first || req_ready) hold_ok = 0;
    end
    if (hold > 0) chk({tag, " R7 hold"}, hold_ok, 1);
    chk({tag, " duration"}, res_dur, exp);
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    chk({tag, " R7 consumed"}, {res_valid, req_ready}, 2'b01);
  endtask

  task automatic check_fill(input string tag, input int mode, input bit hi);
    int ea[32], ed[32];
    int n = 0;
    for (int i = 0; i < 12; i++) begin
      int r = rates[ack_of(i, hi)];
      ea[n] = i; ed[n] = int'(model(10, r, mode, 0)); n++;
      if (ack_of(i, hi) >= 1 && ack_of(i, hi) <= 3) begin
        ea[n] = i + 16; ed[n] = int'(model(10, r, mode, 1)); n++;
      end
    end
    chk({tag, " R10 write count"}, wr_n, n);
    for (int j = 0; j < n && j < wr_n; j++) begin
      chk($sformatf("%s R10 addr #%0d", tag, j), wr_addr[j], ea[j]);
      chk($sformatf("%s %s data #%0d", tag, hi ? "R9" : "R8", j), wr_data[j], ed[j]);
      chk($sformatf("%s R10 done flag #%0d", tag, j), wr_last[j], (j == n - 1) ? 1 : 0);
    end
  endtask

  task automatic wait_fill();
    int cnt = 0;
    while (!(wr_n > 0 && wr_last[wr_n-1] == 1) && cnt < 5000) begin @(negedge clk); cnt++; end
  endtask

  task automatic do_fill(input string tag, input int mode, input bit hi);
    @(negedge clk);
    wr_n = 0;
    req_mode = 2'(mode); fill_ack_high = hi; fill_start = 1;
    @(negedge clk);
    fill_start = 0;
    chk({tag, " R11 blocked during fill"}, req_ready, 0);
    wait_fill();
    check_fill(tag, mode, hi);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    set_cfg(22, 4, 16, 14, 16, 8, 32, 64);
    repeat (3) @(negedge clk);
    chk("R7 reset state", {req_ready, res_valid, tbl_we, fill_done}, 4'b1000);
    rst_n = 1;

    // directed arithmetic
    do_req("R1 ack 6M", 10, 60, 0, 0, 0);
    do_req("R1 long 54M", 1500, 540, 0, 0, 2);
    do_req("R1 empty", 0, 10, 0, 0, 0);
    do_req("R2 odd rate", 100, 55, 2, 0, 1);
    do_req("R2 54M", 100, 540, 2, 0, 0);
    do_req("R3 odd rate", 100, 55, 3, 0, 0);
    do_req("R4 turbo", 200, 540, 1, 0, 0);
    do_req("R5 short default", 14, 20, 0, 1, 0);
    do_req("R5 short ignored half", 14, 20, 2, 1, 0);
    do_req("R5 short ignored turbo", 14, 20, 1, 1, 0);
    do_req("R6 zero rate", 100, 0, 0, 0, 0);
    do_req("R6 overflow quarter", 4095, 10, 3, 0, 3);
    set_cfg(0, 4, 0, 0, 0, 0, 0, 0);
    do_req("R5 floor zero", 0, 60, 0, 1, 0);
    set_cfg(0, 4, 0, 0, 4, 0, 0, 0);
    do_req("R5 just above cut", 12, 10, 0, 1, 0);
    set_cfg(22, 0, 16, 14, 16, 8, 32, 64);
    do_req("R6 zero symbol", 50, 60, 0, 0, 0);
    set_cfg(22, 4, 16, 14, 16, 8, 32, 64);

    // table fills
    do_fill("fill base default", 0, 0);
    do_fill("fill high default", 0, 1);
    do_fill("fill high half", 2, 1);

    // fill start colliding with a pending request
    @(negedge clk);
    wr_n = 0;
    req_len = 12'd300; req_rate = 10'd240; req_mode = 2'd0; req_short = 0; req_valid = 1;
    fill_ack_high = 0; fill_start = 1;
    #1 chk("R11 ready masked by fill_start", req_ready, 0);
    @(negedge clk);
    fill_start = 0;
    wait_fill();
    chk("R11 fill before request", wr_n, 12);
    begin
      int cnt = 0;
      while (!req_ready && cnt < 100) begin @(negedge clk); cnt++; end
      @(negedge clk);
      req_valid = 0;
      cnt = 0;
      while (!res_valid && cnt < 2000) begin @(negedge clk); cnt++; end
      chk("R11 pending request served", res_dur, model(300, 240, 0, 0));
      res_ready = 1;
      @(negedge clk);
      res_ready = 0;
    end

    // randomised traffic
    for (int t = 0; t < 150; t++) begin
      int md = int'($urandom_range(0, 3));
      if (t % 25 == 0)
        set_cfg(int'($urandom_range(0, 63)), int'($urandom_range(0, 12)), int'($urandom_range(0, 60)),
                int'($urandom_range(0, 40)), int'($urandom_range(0, 40)), int'($urandom_range(0, 40)),
                int'($urandom_range(0, 80)), int'($urandom_range(0, 160)));
      do_req($sformatf("%s random %0d", mtag(md), t), int'($urandom_range(0, 4095)),
             int'($urandom_range(0, 1023)), md, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
    end
    summary();
  end
endmodule